// File: doc/BRIEF.md
# SPI NOR Flash Write-Protection Unit

This block is the status and protection unit of a serial NOR flash device. It decodes single-cycle command strobes for the following operations:

- setting and clearing the write-enable latch;
- reading the status byte;
- writing the status byte;
- reading the device identifier.

It holds the latch and the protection configuration: a four-bit protect code, a bottom/top select and a status-write lock bit. From these it tells the array controller whether a program or erase at a given byte address may go ahead.

The array controller presents the target address of a pending program or erase on `op_addr`. It reads the qualifier `op_allow` combinationally. It pulses `op_req` when the operation is launched or refused, and that pulse consumes the write-enable latch. The protect code selects a power-of-two count of sectors. The select bit places that range either at the top of the array or from sector 0 upward. A status write is refused when the write-protect pin is low and the lock bit is set.

Top module: `spi_nor_wprot`

## Requirements
- R1: After reset the status byte reads 0x00, `op_allow` is 0 and `rsp_valid` is 0.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch appears in status bit 1.
- R3: Command 0x05 raises `rsp_valid` for the cycle after the strobe. `rsp_data[23:8]` is then 0 and `rsp_data[7:0]` is the status byte: bit 7 lock, bit 6 code bit 3, bit 5 bottom select, bits 4..2 code bits 2..0, bit 1 latch, bit 0 always 0.
- R4: Command 0x9F raises `rsp_valid` for the cycle after the strobe, with `rsp_data` = 0x20BA19.
- R5: Command 0x01 is accepted when the latch is 1 and either `wp_n` is 1 or the lock bit is 0. An accepted write loads status bits 7..2 from `cmd_arg[7:2]`.
- R6: Command 0x01 leaves status bits 7..2 unchanged in either of two cases: `wp_n` is 0 while the lock bit is 1, or the latch is 0.
- R7: The latch is 0 in the cycle after any 0x01 command, whether it was accepted or refused. It is also 0 in the cycle after any `op_req` pulse, and `op_req` overrides a 0x06 strobe in the same cycle.
- R8: The protect code N = {bit 6, bits 4..2} protects no sectors when N = 0. Otherwise it protects min(2^(N-1), 512) sectors of 64 KiB each.
- R9: With bottom select 0 the protected sectors are the highest ones, ending at sector 511. With bottom select 1 they start at sector 0.
- R10: `op_allow` is 1 exactly when the latch is 1 and sector `op_addr[24:16]` is not protected. It follows `op_addr` in the same cycle and ignores `op_addr[15:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 8 | Command opcode |
| cmd_arg | input | 8 | Argument byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_addr | input | 25 | Byte address of the pending program or erase |
| op_req | input | 1 | Program or erase launched or refused; consumes the latch |
| op_allow | output | 1 | Program or erase at `op_addr` is permitted |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 24 | Status byte or identifier |

## Verification
A behavioural model in the bench follows the status register, the latch and the response, and it is compared with the outputs on every cycle. The status writes are tried with four combinations: each of the two pin levels crossed with each of the two lock values. Writes issued with the latch clear are also tried. Together these separate the lock gate from the latch gate. For every protect code and both select values, the address is swept across all 512 sectors. This separates an off-by-one range boundary, a saturating count and a swapped top/bottom placement. Same-cycle `op_req` with a latch set shows which of the two has priority.

// File: rtl/spi_nor_wprot_pkg.sv
package spi_nor_wprot_pkg;
   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_WRDI = 8'h04;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_WRSR = 8'h01;
   localparam logic [7:0] OPC_RDID = 8'h9F;

   localparam int ST_WEL  = 1;
   localparam int ST_BP0  = 2;
   localparam int ST_TB   = 5;
   localparam int ST_BP3  = 6;
   localparam int ST_LOCK = 7;

   localparam logic [23:0] DEV_ID = 24'h20BA19;

   typedef struct packed {
      logic       lock;
      logic [3:0] code;
      logic       bottom;
   } prot_cfg_t;
endpackage

// File: rtl/wprot_status.sv
module wprot_status
   import spi_nor_wprot_pkg::*;
#(
   parameter bit HAS_BOTTOM = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   input  logic [7:0] cmd_arg,
   input  logic       wp_n,
   input  logic       op_req,
   output prot_cfg_t  cfg,
   output logic       wel,
   output logic [7:0] status_byte
);
   prot_cfg_t cfg_q, cfg_d;
   logic      wel_q;
   logic      bottom_in;
   logic      hit_wren, hit_wrdi, hit_wrsr, sr_open, sr_load;

   assign hit_wren = cmd_valid && (cmd_code == OPC_WREN);
   assign hit_wrdi = cmd_valid && (cmd_code == OPC_WRDI);
   assign hit_wrsr = cmd_valid && (cmd_code == OPC_WRSR);
   assign sr_open  = wp_n || !cfg_q.lock;
   assign sr_load  = hit_wrsr && wel_q && sr_open;

   generate
      if (HAS_BOTTOM) begin : g_bottom
         assign bottom_in = cmd_arg[ST_TB];
      end else begin : g_top_only
         logic unused_tb;
         assign unused_tb = cmd_arg[ST_TB];
         assign bottom_in = 1'b0;
      end
   endgenerate

   logic unused_arg;
   assign unused_arg = ^cmd_arg[1:0];

   always_comb begin
      cfg_d.lock   = cmd_arg[ST_LOCK];
      cfg_d.code   = {cmd_arg[ST_BP3], cmd_arg[ST_BP0+2:ST_BP0]};
      cfg_d.bottom = bottom_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         wel_q <= 1'b0;
      end else begin
         if (sr_load) cfg_q <= cfg_d;
         if (op_req || hit_wrsr || hit_wrdi) wel_q <= 1'b0;
         else if (hit_wren)                  wel_q <= 1'b1;
      end
   end

   assign cfg = cfg_q;
   assign wel = wel_q;
   assign status_byte = {cfg_q.lock, cfg_q.code[3], cfg_q.bottom,
                         cfg_q.code[2:0], wel_q, 1'b0};

   // R6
   sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wrsr && !wp_n && cfg_q.lock) |=> $stable(cfg_q));
   // R7
   wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_req || hit_wrsr) |=> !wel_q);
   // R2
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wren && !op_req) |=> wel_q);
endmodule

// File: rtl/wprot_range.sv
module wprot_range
   import spi_nor_wprot_pkg::*;
#(
   parameter int SECT_BITS = 9
) (
   input  prot_cfg_t              cfg,
   input  logic [SECT_BITS-1:0]   sector,
   output logic                   is_prot
);
   localparam int CNT_W = SECT_BITS + 1;
   localparam int NSECT = 1 << SECT_BITS;

   initial begin
      sect_bits_range_chk: assert (SECT_BITS >= 1 && SECT_BITS <= 20);
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] sec_ext;

   always_comb begin
      int shamt;
      shamt = int'(cfg.code) - 1;
      if (cfg.code == 4'd0)       cnt = '0;
      else if (shamt >= SECT_BITS) cnt = CNT_W'(NSECT);
      else                         cnt = CNT_W'(1) << shamt;
   end

   assign sec_ext = {1'b0, sector};
   assign is_prot = cfg.bottom ? (sec_ext < cnt)
                               : (sec_ext >= (CNT_W'(NSECT) - cnt));
endmodule

// File: rtl/spi_nor_wprot.sv
module spi_nor_wprot
   import spi_nor_wprot_pkg::*;
#(
   parameter int SECT_BITS  = 9,
   parameter int SECT_LG    = 16,
   parameter bit HAS_BOTTOM = 1'b1,
   localparam int ADDR_W    = SECT_BITS + SECT_LG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic [7:0]        cmd_arg,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic              op_req,
   output logic              op_allow,
   output logic              rsp_valid,
   output logic [23:0]       rsp_data
);
   initial begin
      sect_lg_range_chk: assert (SECT_LG >= 8 && SECT_LG <= 24);
   end

   prot_cfg_t  cfg;
   logic       wel, is_prot;
   logic [7:0] status_byte;
   logic       rsp_v_q;
   logic [23:0] rsp_d_q;

   logic unused_low;
   assign unused_low = ^op_addr[SECT_LG-1:0];

   wprot_status #(.HAS_BOTTOM(HAS_BOTTOM)) status_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_arg(cmd_arg), .wp_n(wp_n), .op_req(op_req),
      .cfg(cfg), .wel(wel), .status_byte(status_byte)
   );

   wprot_range #(.SECT_BITS(SECT_BITS)) range_i (
      .cfg(cfg), .sector(op_addr[ADDR_W-1:SECT_LG]), .is_prot(is_prot)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= cmd_valid && (cmd_code == OPC_RDSR || cmd_code == OPC_RDID);
         if (cmd_valid && cmd_code == OPC_RDID)      rsp_d_q <= DEV_ID;
         else if (cmd_valid && cmd_code == OPC_RDSR) rsp_d_q <= {16'h0, status_byte};
      end
   end

   assign op_allow  = wel && !is_prot;
   assign rsp_valid = rsp_v_q;
   assign rsp_data  = rsp_d_q;

   // R10
   allow_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_allow |-> wel);
   // R3
   rdsr_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == OPC_RDSR) |=> (rsp_valid && rsp_data[23:8] == 16'h0));
   // R4
   rdid_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == OPC_RDID) |=> (rsp_valid && rsp_data == DEV_ID));
endmodule

// File: tb/spi_nor_wprot_tb_top.sv
module spi_nor_wprot_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NSECT = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = 8'h00;
   logic [7:0]  cmd_arg = 8'h00;
   logic        wp_n = 1'b1;
   logic [24:0] op_addr = '0;
   logic        op_req = 1'b0;
   logic        op_allow, rsp_valid;
   logic [23:0] rsp_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_nor_wprot dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_arg(cmd_arg), .wp_n(wp_n), .op_addr(op_addr), .op_req(op_req),
      .op_allow(op_allow), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   // behavioural reference state
   int m_wel, m_lock, m_code, m_bot, m_rv, m_rd;

   function automatic int m_status();
      return (m_lock << 7) | (((m_code >> 3) & 1) << 6) | (m_bot << 5)
           | ((m_code & 7) << 2) | (m_wel << 1);
   endfunction

   function automatic bit m_prot(int sec);
      int cnt;
      if (m_code == 0) cnt = 0;
      else if (m_code - 1 >= 9) cnt = NSECT;
      else cnt = 1 << (m_code - 1);
      return m_bot ? (sec < cnt) : (sec >= NSECT - cnt);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wel <= 0; m_lock <= 0; m_code <= 0; m_bot <= 0; m_rv <= 0; m_rd <= 0;
      end else begin
         m_rv <= 0;
         if (cmd_valid) begin
            case (cmd_code)
               8'h06: m_wel <= 1;
               8'h04: m_wel <= 0;
               8'h05: begin m_rv <= 1; m_rd <= m_status(); end
               8'h9F: begin m_rv <= 1; m_rd <= 32'h20BA19; end
               8'h01: begin
                  if (m_wel == 1 && (wp_n || m_lock == 0)) begin
                     m_lock <= cmd_arg[7];
                     m_code <= {cmd_arg[6], cmd_arg[4:2]};
                     m_bot  <= cmd_arg[5];
                  end
                  m_wel <= 0;
               end
               default: ;
            endcase
         end
         if (op_req) m_wel <= 0;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // lockstep compare every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 R9 R10 op_allow", int'(op_allow),
             (m_wel == 1 && !m_prot(int'(op_addr[24:16]))) ? 1 : 0);
         chk("R3 R4 rsp_valid", int'(rsp_valid), m_rv);
         if (m_rv == 1) chk("R3 R4 rsp_data", int'(rsp_data), m_rd);
      end
   end

   task automatic issue(logic [7:0] code, logic [7:0] arg);
      @(posedge clk); #2;
      cmd_valid = 1'b1; cmd_code = code; cmd_arg = arg;
      @(posedge clk); #2;
      cmd_valid = 1'b0;
   endtask

   task automatic read_sr(output int v);
      issue(8'h05, 8'h00);
      @(negedge clk);
      v = int'(rsp_data[7:0]);
   endtask

   task automatic set_sr(logic [7:0] v);
      issue(8'h06, 8'h00);
      issue(8'h01, v);
   endtask

   task automatic at_sector(int sec, int low);
      @(posedge clk); #2;
      op_addr = 25'((sec << 16) | low);
   endtask

   initial begin
      int v;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 op_allow", int'(op_allow), 0);
      chk("R1 rsp_valid", int'(rsp_valid), 0);
      read_sr(v); chk("R1 status", v, 8'h00);

      // R2
      issue(8'h06, 8'h00); read_sr(v); chk("R2 wel set", v, 8'h02);
      issue(8'h04, 8'h00); read_sr(v); chk("R2 wel clear", v, 8'h00);

      // R4
      issue(8'h9F, 8'h00); @(negedge clk);
      chk("R4 id", int'(rsp_data), 24'h20BA19);

      // R6: no latch
      issue(8'h01, 8'h80); read_sr(v); chk("R6 no latch", v, 8'h00);

      // R5 wp high
      set_sr(8'h80); read_sr(v); chk("R5 wp high set lock", v, 8'h80);
      set_sr(8'h00); read_sr(v); chk("R5 wp high clear lock", v, 8'h00);
      // R5 wp low, lock 0
      wp_n = 1'b0;
      set_sr(8'h80); read_sr(v); chk("R5 wp low unlocked", v, 8'h80);
      // R6 / R7 wp low, lock 1
      set_sr(8'h1C); read_sr(v); chk("R6 R7 locked write", v, 8'h80);
      wp_n = 1'b1;
      set_sr(8'h00); read_sr(v); chk("R5 unlock", v, 8'h00);

      // R7 op_req
      issue(8'h06, 8'h00);
      @(posedge clk); #2 op_req = 1'b1;
      @(posedge clk); #2 op_req = 1'b0;
      read_sr(v); chk("R7 op_req clears", v, 8'h00);
      @(posedge clk); #2 cmd_valid = 1'b1; cmd_code = 8'h06; op_req = 1'b1;
      @(posedge clk); #2 cmd_valid = 1'b0; op_req = 1'b0;
      read_sr(v); chk("R7 op_req wins", v, 8'h00);

      // R8 R9 sweep all codes and placements
      for (int bot = 0; bot < 2; bot++) begin
         for (int code = 0; code < 16; code++) begin
            set_sr(8'((((code >> 3) & 1) << 6) | (bot << 5) | ((code & 7) << 2)));
            issue(8'h06, 8'h00);
            for (int s = 0; s < NSECT; s++) at_sector(s, (s * 37) & 16'hFFFF);
         end
      end

      // R9 directed boundaries, code 3 = 4 sectors
      set_sr(8'h2C); issue(8'h06, 8'h00);
      at_sector(3, 0);   @(negedge clk); chk("R9 bottom edge in", int'(op_allow), 0);
      at_sector(4, 0);   @(negedge clk); chk("R9 bottom edge out", int'(op_allow), 1);
      set_sr(8'h0C); issue(8'h06, 8'h00);
      at_sector(507, 16'hFFFF); @(negedge clk); chk("R9 R10 top edge out", int'(op_allow), 1);
      at_sector(508, 0);        @(negedge clk); chk("R9 top edge in", int'(op_allow), 0);
      // R8 code 9 = 256 sectors, code 15 saturates
      set_sr(8'h44); issue(8'h06, 8'h00);
      at_sector(255, 0); @(negedge clk); chk("R8 code9 out", int'(op_allow), 1);
      at_sector(256, 0); @(negedge clk); chk("R8 code9 in", int'(op_allow), 0);
      set_sr(8'h5C); issue(8'h06, 8'h00);
      at_sector(0, 0);   @(negedge clk); chk("R8 code15 all", int'(op_allow), 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule